// File: doc/BRIEF.md
# LFSR Sequence Self-Test Checker

This block decides whether a small buffer of captured 64-bit words follows a known linear-feedback sequence. A start pulse launches a check. The block loads an expected value from one of two seed inputs, chosen by a version-select input. It then works in iterations. Each iteration scans the buffer, leaving out the first word, and adds up how many words equal the current expected value. The sum is carried from one iteration to the next. When the sum reaches a match goal, the check passes. Otherwise the expected value takes one LFSR step and the scan repeats. If an iteration limit is reached first, the check fails.

The buffer is filled beforehand through a simple write port. One buffer word is compared per clock. An iteration therefore costs `DEPTH - 1` compare cycles plus one evaluation cycle, which is `DEPTH` cycles in total. The result is a one-cycle `done` pulse that comes with exactly one of `pass` or `fail`.

Top module: `lfsr_seq_checker`

## Requirements
- R1: While `rst_n` is low, `done`, `pass` and `fail` are all low.
- R2: One LFSR step shifts the 64-bit value left by one bit and fills bit 0 with zero. If bit 63 was 1 before the shift, the result is then XORed with `poly`.
- R3: Buffer word at address 0 is never compared. Only addresses 1 to `DEPTH-1` can produce matches.
- R4: Matches found in each iteration are added to a running total that persists across all iterations of one check.
- R5: The check passes at the first iteration after which the running total is at least `MATCH_GOAL`. For a pass in iteration k (counting from 0), `done` and `pass` are high `DEPTH*(k+1)` clock edges after the edge that accepted `start`. The expected value is stepped only between iterations that have not met the goal.
- R6: If `LOOP_MAX` iterations finish without reaching the goal, `done` and `fail` are high `DEPTH*LOOP_MAX` edges after the accepting edge.
- R7: When `start` is accepted, the first expected value is `seed_a` if `ver_sel` is 0 and `seed_b` if `ver_sel` is 1.
- R8: `done` is high for exactly one cycle. In that cycle exactly one of `pass` and `fail` is high, and neither is high outside it.
- R9: A `start` pulse, or a change of `ver_sel`, while a check is running has no effect on that check's timing or result.
- R10: When `wr_en` is high at a clock edge, `wr_data` is stored at `wr_addr`. The stored word replaces any earlier content at that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Buffer write strobe |
| wr_addr | input | $clog2(DEPTH) | Buffer write address |
| wr_data | input | WORD_W | Buffer write data |
| start | input | 1 | Launches a check when idle |
| ver_sel | input | 1 | Seed choice: 0 selects seed_a, 1 selects seed_b |
| seed_a | input | WORD_W | First seed |
| seed_b | input | WORD_W | Second seed |
| poly | input | WORD_W | Feedback polynomial mask |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Goal met (with done) |
| fail | output | 1 | Iteration limit hit (with done) |

## Verification
Two outcomes are the hardest to reach from the ports. One is a pass in the very last allowed iteration. The other is a pass built from single matches spread across several iterations. Both need buffer words that equal values many LFSR steps away from the seed. The bench computes the LFSR sequence arithmetically and plants chosen steps at chosen addresses. It sweeps the iteration where the goal is met across the whole limit, and it places the seed in word 0 to show that word is skipped. A reference model of the scan gives the expected latency and verdict for every buffer pattern.

// File: rtl/lfsr_chk_pkg.sv
package lfsr_chk_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SCAN = 2'd1,
      ST_EVAL = 2'd2
   } chk_state_e;
endpackage

// File: rtl/lfsr_chk_buf.sv
module lfsr_chk_buf #(
   parameter int WORD_W = 64,
   parameter int DEPTH  = 8,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [AW-1:0]     rd_addr,
   output logic [WORD_W-1:0] rd_data
);
   logic [WORD_W-1:0] word_q [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            word_q[g] <= '0;
         else if (wr_en && (wr_addr == AW'(g)))
            word_q[g] <= wr_data;
      end
   end

   assign rd_data = word_q[rd_addr];
endmodule

// File: rtl/lfsr_chk_step.sv
module lfsr_chk_step #(
   parameter int WORD_W = 64
) (
   input  logic [WORD_W-1:0] cur,
   input  logic [WORD_W-1:0] poly,
   output logic [WORD_W-1:0] nxt
);
   logic [WORD_W-1:0] shifted;

   assign shifted = {cur[WORD_W-2:0], 1'b0};
   assign nxt     = cur[WORD_W-1] ? (shifted ^ poly) : shifted;
endmodule

// File: rtl/lfsr_chk_ctrl.sv
module lfsr_chk_ctrl
   import lfsr_chk_pkg::*;
#(
   parameter int WORD_W     = 64,
   parameter int DEPTH      = 8,
   parameter int MATCH_GOAL = 3,
   parameter int LOOP_MAX   = 12,
   localparam int AW        = $clog2(DEPTH),
   localparam int IW        = $clog2(LOOP_MAX + 1),
   localparam int TW        = $clog2(MATCH_GOAL + DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              ver_sel,
   input  logic [WORD_W-1:0] seed_a,
   input  logic [WORD_W-1:0] seed_b,
   output logic [AW-1:0]     rd_addr,
   input  logic [WORD_W-1:0] rd_data,
   output logic [WORD_W-1:0] exp_cur,
   input  logic [WORD_W-1:0] exp_nxt,
   output logic              busy,
   output logic              done,
   output logic              pass,
   output logic              fail
);
   chk_state_e        state_q;
   logic [WORD_W-1:0] exp_q;
   logic [IW-1:0]     iter_q;
   logic [AW-1:0]     idx_q;
   logic [TW-1:0]     total_q;
   logic              done_q, pass_q, fail_q;
   logic              hit, last_word, goal_met, last_iter;

   assign hit       = (rd_data == exp_q);
   assign last_word = (idx_q == AW'(DEPTH - 1));
   assign goal_met  = (total_q >= TW'(MATCH_GOAL));
   assign last_iter = (iter_q == IW'(LOOP_MAX - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         exp_q   <= '0;
         iter_q  <= '0;
         idx_q   <= '0;
         total_q <= '0;
         done_q  <= 1'b0;
         pass_q  <= 1'b0;
         fail_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         pass_q <= 1'b0;
         fail_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  exp_q   <= ver_sel ? seed_b : seed_a;
                  iter_q  <= '0;
                  idx_q   <= AW'(1);
                  total_q <= '0;
                  state_q <= ST_SCAN;
               end
            end
            ST_SCAN: begin
               total_q <= total_q + TW'(hit);
               if (last_word)
                  state_q <= ST_EVAL;
               else
                  idx_q <= idx_q + 1'b1;
            end
            ST_EVAL: begin
               if (goal_met) begin
                  done_q  <= 1'b1;
                  pass_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end else if (last_iter) begin
                  done_q  <= 1'b1;
                  fail_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end else begin
                  exp_q   <= exp_nxt;
                  iter_q  <= iter_q + 1'b1;
                  idx_q   <= AW'(1);
                  state_q <= ST_SCAN;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign rd_addr = idx_q;
   assign exp_cur = exp_q;
   assign busy    = (state_q != ST_IDLE);
   assign done    = done_q;
   assign pass    = pass_q;
   assign fail    = fail_q;
endmodule

// File: rtl/lfsr_seq_checker.sv
module lfsr_seq_checker #(
   parameter int WORD_W     = 64,
   parameter int DEPTH      = 8,
   parameter int MATCH_GOAL = 3,
   parameter int LOOP_MAX   = 12,
   localparam int AW        = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              start,
   input  logic              ver_sel,
   input  logic [WORD_W-1:0] seed_a,
   input  logic [WORD_W-1:0] seed_b,
   input  logic [WORD_W-1:0] poly,
   output logic              done,
   output logic              pass,
   output logic              fail
);
   if (WORD_W < 2) begin : g_bad_width
      $error("lfsr_seq_checker: WORD_W must be at least 2");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("lfsr_seq_checker: DEPTH must be at least 2");
   end
   if (MATCH_GOAL < 1) begin : g_bad_goal
      $error("lfsr_seq_checker: MATCH_GOAL must be at least 1");
   end
   if (LOOP_MAX < 1) begin : g_bad_loop
      $error("lfsr_seq_checker: LOOP_MAX must be at least 1");
   end

   logic [AW-1:0]     rd_addr;
   logic [WORD_W-1:0] rd_data;
   logic [WORD_W-1:0] exp_cur;
   logic [WORD_W-1:0] exp_nxt;
   logic              busy;

   lfsr_chk_buf #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );

   lfsr_chk_step #(.WORD_W(WORD_W)) u_step (
      .cur  (exp_cur),
      .poly (poly),
      .nxt  (exp_nxt)
   );

   lfsr_chk_ctrl #(
      .WORD_W     (WORD_W),
      .DEPTH      (DEPTH),
      .MATCH_GOAL (MATCH_GOAL),
      .LOOP_MAX   (LOOP_MAX)
   ) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .ver_sel (ver_sel),
      .seed_a  (seed_a),
      .seed_b  (seed_b),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .exp_cur (exp_cur),
      .exp_nxt (exp_nxt),
      .busy    (busy),
      .done    (done),
      .pass    (pass),
      .fail    (fail)
   );
endmodule

// File: rtl/lfsr_seq_checker_chk.sv
module lfsr_seq_checker_chk #(
   parameter int DEPTH    = 8,
   parameter int LOOP_MAX = 12,
   localparam int CW      = $clog2(DEPTH * LOOP_MAX + 1) + 1
) (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic busy,
   input logic done,
   input logic pass,
   input logic fail
);
   logic          running_q;
   logic [CW-1:0] cyc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running_q <= 1'b0;
         cyc_q     <= '0;
      end else if (start && !busy) begin
         running_q <= 1'b1;
         cyc_q     <= '0;
      end else if (running_q) begin
         if (done)
            running_q <= 1'b0;
         else
            cyc_q <= cyc_q + 1'b1;
      end
   end

   // R1
   rst_quiet_chk: assert property (@(posedge clk) !rst_n |-> (!done && !pass && !fail));

   // R8
   verdict_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done || pass || fail) |-> (done && (pass != fail)));

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);

   // R5
   iter_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (running_q && (cyc_q != '0) && ((cyc_q % CW'(DEPTH)) == '0)));

   // R6
   fail_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fail |-> (cyc_q == CW'(DEPTH * LOOP_MAX)));

   // R9
   launch_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));
endmodule

bind lfsr_seq_checker lfsr_seq_checker_chk #(.DEPTH(DEPTH), .LOOP_MAX(LOOP_MAX)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .start (start),
   .busy  (busy),
   .done  (done),
   .pass  (pass),
   .fail  (fail)
);

// File: tb/lfsr_seq_checker_bench.sv
`timescale 1ns/1ps
module lfsr_seq_checker_bench;
   localparam int W     = 64;
   localparam int DEPTH = 8;
   localparam int GOAL  = 3;
   localparam int LOOPS = 12;
   localparam int AW    = $clog2(DEPTH);
   localparam logic [W-1:0] SEED_A = 64'h9C3A_51E7_0D2B_F468;
   localparam logic [W-1:0] SEED_B = 64'h1B7E_2C90_A5D3_4F06;
   localparam logic [W-1:0] POLY   = 64'h2649_C1B7_3A8E_50D5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [W-1:0]  wr_data = '0;
   logic          start = 1'b0;
   logic          ver_sel = 1'b0;
   logic          done, pass, fail;

   int total = 0;
   int bad = 0;
   logic [W-1:0] shadow [DEPTH];

   always #4 clk = ~clk;

   lfsr_seq_checker #(.WORD_W(W), .DEPTH(DEPTH), .MATCH_GOAL(GOAL), .LOOP_MAX(LOOPS)) u_lfsr_seq_checker (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .start(start), .ver_sel(ver_sel), .seed_a(SEED_A), .seed_b(SEED_B), .poly(POLY),
      .done(done), .pass(pass), .fail(fail)
   );

   // R2 reference step
   function automatic logic [W-1:0] step(input logic [W-1:0] v);
      logic [W-1:0] s;
      s = v << 1;
      if (v[W-1]) s = s ^ POLY;
      return s;
   endfunction

   function automatic logic [W-1:0] step_n(input logic [W-1:0] v, input int n);
      logic [W-1:0] r;
      r = v;
      for (int i = 0; i < n; i++) r = step(r);
      return r;
   endfunction

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // reference model of the scan (R3 R4 R5 R6 R7)
   task automatic model(input bit sel, output bit ok, output int lat);
      logic [W-1:0] v;
      int tot;
      v = sel ? SEED_B : SEED_A;
      tot = 0;
      ok = 1'b0;
      lat = DEPTH * LOOPS;
      for (int it = 0; it < LOOPS; it++) begin
         for (int w = 1; w < DEPTH; w++) if (shadow[w] == v) tot++;
         if (tot >= GOAL) begin
            ok = 1'b1;
            lat = DEPTH * (it + 1);
            return;
         end
         v = step(v);
      end
   endtask

   // R10 write port, called just after a negedge
   task automatic wr(input int a, input logic [W-1:0] d);
      wr_en = 1'b1;
      wr_addr = AW'(a);
      wr_data = d;
      shadow[a] = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic fill_junk();
      for (int a = 0; a < DEPTH; a++) wr(a, 64'h5A5A_0000_0000_0000 + 64'(a * 7919));
   endtask

   task automatic run(input bit sel, input bit poke, input string tag);
      bit eok;
      int elat, n;
      bit seen;
      model(sel, eok, elat);
      ver_sel = sel;
      start = 1'b1;
      n = 0;
      seen = 1'b0;
      while (!seen && n < 4000) begin
         @(posedge clk);
         n++;
         @(negedge clk);
         start = 1'b0;
         ver_sel = sel;
         if (poke && (n == 5 || n == 30 || n == 61)) begin
            start = 1'b1;
            ver_sel = ~sel;
         end
         if (done) seen = 1'b1;
      end
      start = 1'b0;
      ver_sel = sel;
      chk(seen, {tag, " done seen"}, seen, 1);
      chk((n - 1) == elat, {tag, " latency"}, n - 1, elat);
      chk(pass == eok && fail == !eok, {tag, " R8 verdict"}, {pass, fail}, {eok, !eok});
      @(posedge clk);
      @(negedge clk);
      chk(!done && !pass && !fail, {tag, " R8 single pulse"}, {done, pass, fail}, 0);
   endtask

   initial begin
      #(8 * 200000);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // R1 reset state
      #1;
      chk(!done && !pass && !fail, "R1 in reset", {done, pass, fail}, 0);
      repeat (3) @(negedge clk);
      chk(!done && !pass && !fail, "R1 in reset later", {done, pass, fail}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R5 R7: immediate pass from seed_a
      fill_junk();
      for (int a = 1; a <= 3; a++) wr(a, SEED_A);
      run(1'b0, 1'b0, "R5 R7 seed_a pass iter0");
      // R7: same buffer with seed_b must fail (R6)
      run(1'b1, 1'b0, "R6 R7 seed_b fail");

      // R3: seed only in word 0 and two real copies -> fail (goal missed by one)
      fill_junk();
      wr(0, SEED_B);
      wr(2, SEED_B);
      wr(5, SEED_B);
      run(1'b1, 1'b0, "R3 R5 word0 skipped");
      // R10: overwrite word 7 supplies third match -> pass
      wr(7, SEED_B);
      run(1'b1, 1'b0, "R10 R5 rewrite pass");

      // R2 R4: single matches spread over three iterations
      fill_junk();
      wr(1, step_n(SEED_A, 1));
      wr(4, step_n(SEED_A, 3));
      wr(6, step_n(SEED_A, 5));
      run(1'b0, 1'b0, "R2 R4 spread matches");

      // R5: more matches than goal in one iteration
      for (int a = 0; a < DEPTH; a++) wr(a, SEED_A);
      run(1'b0, 1'b0, "R5 excess matches");

      // R5 R6 sweep: goal met in every possible iteration, incl. the last
      for (int k = 0; k < LOOPS; k++) begin
         fill_junk();
         wr(2, step_n(SEED_B, k));
         wr(3, step_n(SEED_B, k));
         wr(7, step_n(SEED_B, k));
         run(1'b1, 1'b0, $sformatf("R2 R5 sweep k=%0d", k));
      end

      // R6: goal one short of the limit, match one step beyond last iteration
      fill_junk();
      for (int a = 1; a <= 3; a++) wr(a, step_n(SEED_A, LOOPS));
      run(1'b0, 1'b0, "R6 beyond limit");

      // R9: start and ver_sel toggles during a running fail check
      fill_junk();
      run(1'b0, 1'b1, "R9 restart ignored");
      // R9: during a late pass with seed_b
      for (int a = 4; a <= 6; a++) wr(a, step_n(SEED_B, 9));
      run(1'b1, 1'b1, "R9 late pass kept");

      // R1: reset mid-run clears outputs
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk(!done && !pass && !fail, "R1 reset mid-run", {done, pass, fail}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (DEPTH * LOOPS + 4) begin
         @(negedge clk);
         if (done) chk(1'b0, "R1 no result after reset", done, 0);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule